// File: doc/BRIEF.md
# Runtime-Configurable LFSR with Cycle-Length Meter

This block is a Fibonacci-form linear feedback shift register whose length (1 to 20 bits), feedback tap set and start value are all chosen at run time through a load strobe. On every enabled step the register moves one place toward bit 0. The bit leaving at the bottom is the serial output. A new bit, the XOR of the tapped bits, enters at the top of the configured length. The whole register value is also available in parallel.

Next to the register sits a meter that remembers the seed of the last load. It counts the enabled steps until the register comes back to that seed and then reports the count as the period. It raises a flag when that period is the largest a register of that length can have. A seed of all zeros is reported as a lockup and no search is made for it. A search that runs 2^n steps without a return ends in a timeout status. This happens with tap sets that leave no path back to the seed.

Top module: `lfsr_meter_top`

## Requirements
- R1: Each enabled step shifts the register one place toward bit 0. `out_bit` always shows bit 0 of the present state, which is the bit that the next step emits. The feedback bit is written into bit n-1, where n is the configured length.
- R2: `cfg_taps` bit p-1 selects tap position p. Tap position p feeds register bit n-p into the feedback XOR. With n=4, taps at positions 4 and 1 (`cfg_taps`=0x9) and seed 0x8, the first 15 output bits are 000111101011001, and the period is 15.
- R3: Register bits at index n and above are always zero. Seed and tap bits above the configured length have no effect.
- R4: A load sets the state to the masked seed on the next cycle. It clears every status output and the period. It takes priority over a step in the same cycle.
- R5: While `step_en` and `cfg_load` are both low, the state and all status outputs hold.
- R6: `period_valid` rises at the step that first brings the register back to the seed after a load. `period` then holds that step count, and both stay until the next load.
- R7: `maximal` is high only together with `period_valid`, and only when the period equals 2^n-1. The tap sets {3,2} for n=3, {5,2} for n=5, {8,4,3,2} for n=8 and {10,3} for n=10 all give the full period.
- R8: A seed whose bits within the configured length are all zero raises `lockup`. The register then stays zero, and `period_valid` and `timeout` stay low.
- R9: If 2^n steps pass after a load without a return to the seed, `timeout` rises at the 2^n-th step and `period_valid` stays low.
- R10: After reset, the state, `out_bit`, `period` and every status flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 5 | Register length n, 1 to 20, taken at load |
| cfg_taps | input | 20 | Tap set; bit p-1 set means tap position p |
| cfg_seed | input | 20 | Start value, masked to n bits at load |
| cfg_load | input | 1 | Load strobe for length, taps and seed |
| step_en | input | 1 | Advance the register by one step |
| out_bit | output | 1 | Bit 0 of the present state |
| state | output | 20 | Parallel register value |
| period | output | 20 | Measured cycle length |
| period_valid | output | 1 | Period found |
| maximal | output | 1 | Period equals 2^n-1 |
| lockup | output | 1 | Loaded seed is all zero |
| timeout | output | 1 | No return within 2^n steps |

## Verification
All registered results are due one clock edge after the stimulus that causes them. The state reflects a load or step at the next edge. `period_valid`, `period` and `maximal` change at the edge of the returning step. `timeout` changes at the edge of the 2^n-th step, and `lockup` changes at the edge of the load. `out_bit` follows the state with no further delay. The bench drives its inputs and samples the outputs on the falling edge. Its behavioural model advances on the rising edge, so every output is compared in the half cycle after the edge that made it due. The explicit checks read the outputs at the falling edge after the last step.

// File: rtl/lfsr_meter_pkg.sv
// Package: shared types for the configurable LFSR and its cycle-length meter.
// Assumes: the meter walks exactly one of these phases after each load.
package lfsr_meter_pkg;

    // Phase of the cycle-length search after a load
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SEARCH,
        PH_FOUND,
        PH_EXPIRED,
        PH_LOCKED
    } meter_phase_t;

endpackage

// File: rtl/lfsr_shift_core.sv
// Module: lfsr_shift_core
// Holds the Fibonacci shift register. It masks the seed and taps to the
// configured length, maps tap positions onto register bits, and forms the next
// state. Assumes the length at load lies in 1..WIDTH.
module lfsr_shift_core #(
    parameter int WIDTH = 20,
    parameter int LEN_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [LEN_W-1:0] len_in,
    input  logic [WIDTH-1:0] taps_in,
    input  logic [WIDTH-1:0] seed_in,
    output logic [WIDTH-1:0] seed_eff,
    output logic [WIDTH-1:0] state_q,
    output logic [WIDTH-1:0] state_nxt,
    output logic [LEN_W-1:0] len_q
);

    logic [WIDTH-1:0] mask_in;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] rev_taps;
    logic [WIDTH-1:0] tapbits_in;
    logic [WIDTH-1:0] tap_q;
    logic [WIDTH-1:0] msb_q;
    logic             fb;

    // Per-bit length masks and bit-reversed tap vector
    genvar j;
    generate
        for (j = 0; j < WIDTH; j++) begin : g_bit
            assign mask_in[j]  = (j < int'(len_in));
            assign mask_q[j]   = (j < int'(len_q));
            assign rev_taps[j] = taps_in[WIDTH-1-j];
        end
    endgenerate

    // Tap position p lands on register bit n-p once the reversed vector is shifted down
    assign tapbits_in = (rev_taps >> (LEN_W'(WIDTH) - len_in)) & mask_in;
    assign seed_eff   = seed_in & mask_in;

    // Top bit of the active length receives the feedback
    assign msb_q     = mask_q & ~(mask_q >> 1);
    assign fb        = ^(state_q & tap_q);
    assign state_nxt = (state_q >> 1) | (fb ? msb_q : '0);

    // Register update: reset, load, or one step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            tap_q   <= '0;
            len_q   <= '0;
        end else if (load) begin
            state_q <= seed_eff;
            tap_q   <= tapbits_in;
            len_q   <= len_in;
        end else if (step) begin
            state_q <= state_nxt;
        end
    end

    // R3: nothing survives above the configured length
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q & ~mask_q) == '0);

    // R5: no load and no step leaves the register untouched
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(state_q));

    // R4: a load wins over a step in the same cycle
    a_r4_load_seed: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state_q == $past(seed_in & mask_in));

    // R1: a plain step moves the lower bits down by one place
    a_r1_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (state_q & ~$past(msb_q)) == ($past(state_q) >> 1));

endmodule

// File: rtl/lfsr_period_meter.sv
// Module: lfsr_period_meter
// Remembers the loaded seed and counts steps until the register returns to it.
// Reports the period, whether it is maximal, a zero-seed lockup, or a timeout
// after 2^n steps. Assumes state_nxt is the value the register takes on a step.
module lfsr_period_meter
    import lfsr_meter_pkg::*;
#(
    parameter int WIDTH = 20,
    parameter int LEN_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [WIDTH-1:0] seed_eff,
    input  logic [WIDTH-1:0] state_nxt,
    input  logic [LEN_W-1:0] len_q,
    output logic [WIDTH-1:0] period,
    output logic             period_valid,
    output logic             maximal,
    output logic             lockup,
    output logic             timeout
);

    localparam int CNT_W = WIDTH + 1;

    meter_phase_t     phase_q;
    logic [WIDTH-1:0] seed_q;
    logic [WIDTH-1:0] period_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] limit;
    logic             max_q;
    logic             hit;

    // Step count after this step, the 2^n bound, and the return test
    assign cnt_inc = cnt_q + CNT_W'(1);
    assign limit   = CNT_W'(1) << len_q;
    assign hit     = (state_nxt == seed_q);

    // Search state machine: arm on load, finish on return or on the bound
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            seed_q   <= '0;
            period_q <= '0;
            cnt_q    <= '0;
            max_q    <= 1'b0;
        end else if (load) begin
            seed_q   <= seed_eff;
            period_q <= '0;
            cnt_q    <= '0;
            max_q    <= 1'b0;
            phase_q  <= (seed_eff == '0) ? PH_LOCKED : PH_SEARCH;
        end else if (step && phase_q == PH_SEARCH) begin
            cnt_q <= cnt_inc;
            if (hit) begin
                phase_q  <= PH_FOUND;
                period_q <= cnt_inc[WIDTH-1:0];
                max_q    <= (cnt_inc == limit - CNT_W'(1));
            end else if (cnt_inc == limit) begin
                phase_q <= PH_EXPIRED;
            end
        end
    end

    // Status decode
    assign period       = period_q;
    assign period_valid = (phase_q == PH_FOUND);
    assign maximal      = max_q;
    assign lockup       = (phase_q == PH_LOCKED);
    assign timeout      = (phase_q == PH_EXPIRED);

    // R7: the maximal flag never stands without a found period
    a_r7_max_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        maximal |-> period_valid);

    // R6: a found period stays put until the next load
    a_r6_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (period_valid && !load) |=> (period_valid && $stable(period)));

    // R6: a reported period is never zero
    a_r6_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid |-> (period != '0));

    // R8: lockup excludes every search outcome
    a_r8_lock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |-> (!period_valid && !timeout && !maximal));

    // R9: a timeout carries no period
    a_r9_no_period: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (period == '0 && !period_valid));

endmodule

// File: rtl/lfsr_meter_top.sv
// Module: lfsr_meter_top
// Joins the shift register and the cycle-length meter. The serial output is
// bit 0 of the present state. Assumes cfg_len lies in 1..WIDTH when loaded.
module lfsr_meter_top #(
    parameter int WIDTH = 20,
    parameter int LEN_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [WIDTH-1:0] cfg_taps,
    input  logic [WIDTH-1:0] cfg_seed,
    input  logic             cfg_load,
    input  logic             step_en,
    output logic             out_bit,
    output logic [WIDTH-1:0] state,
    output logic [WIDTH-1:0] period,
    output logic             period_valid,
    output logic             maximal,
    output logic             lockup,
    output logic             timeout
);

    logic [WIDTH-1:0] seed_eff;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_nxt;
    logic [LEN_W-1:0] len_q;

    lfsr_shift_core #(.WIDTH(WIDTH), .LEN_W(LEN_W)) i_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_load),
        .step      (step_en),
        .len_in    (cfg_len),
        .taps_in   (cfg_taps),
        .seed_in   (cfg_seed),
        .seed_eff  (seed_eff),
        .state_q   (state_q),
        .state_nxt (state_nxt),
        .len_q     (len_q)
    );

    lfsr_period_meter #(.WIDTH(WIDTH), .LEN_W(LEN_W)) i_meter (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (cfg_load),
        .step         (step_en),
        .seed_eff     (seed_eff),
        .state_nxt    (state_nxt),
        .len_q        (len_q),
        .period       (period),
        .period_valid (period_valid),
        .maximal      (maximal),
        .lockup       (lockup),
        .timeout      (timeout)
    );

    assign state   = state_q;
    assign out_bit = state_q[0];

endmodule

// File: tb/test_lfsr_meter_top.sv
`timescale 1ns/1ps
module test_lfsr_meter_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_len = '0;
    logic [19:0] cfg_taps = '0;
    logic [19:0] cfg_seed = '0;
    logic        cfg_load = 1'b0;
    logic        step_en = 1'b0;
    logic        out_bit;
    logic [19:0] state;
    logic [19:0] period;
    logic        period_valid, maximal, lockup, timeout;

    int checks = 0;
    int errors = 0;
    bit live = 0;
    bit done = 0;

    // behavioural reference
    int m_len = 0, m_taps = 0, m_state = 0, m_seed = 0, m_cnt = 0, m_period = 0;
    bit m_search = 0, m_valid = 0, m_max = 0, m_lock = 0, m_to = 0;

    always #2.5 clk = ~clk;

    lfsr_meter_top i_lfsr_meter_top (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_taps(cfg_taps),
        .cfg_seed(cfg_seed), .cfg_load(cfg_load), .step_en(step_en),
        .out_bit(out_bit), .state(state), .period(period),
        .period_valid(period_valid), .maximal(maximal), .lockup(lockup),
        .timeout(timeout)
    );

    function automatic int next_of(int s, int n, int t);
        int f = 0;
        for (int p = 1; p <= n; p++)
            if (((t >> (p - 1)) & 1) == 1) f ^= (s >> (n - p)) & 1;
        return (s >> 1) | (f << (n - 1));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // model advances on the rising edge with the inputs held since the falling edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_len = 0; m_taps = 0; m_state = 0; m_seed = 0; m_cnt = 0; m_period = 0;
            m_search = 0; m_valid = 0; m_max = 0; m_lock = 0; m_to = 0;
        end else if (cfg_load) begin
            m_len = int'(cfg_len);
            m_taps = int'(cfg_taps);
            m_state = int'(cfg_seed) & ((1 << m_len) - 1);
            m_seed = m_state;
            m_cnt = 0; m_period = 0; m_valid = 0; m_max = 0; m_to = 0;
            m_lock = (m_state == 0);
            m_search = !m_lock;
        end else if (step_en) begin
            int nx;
            nx = next_of(m_state, m_len, m_taps);
            if (m_search) begin
                m_cnt++;
                if (nx == m_seed) begin
                    m_valid = 1; m_period = m_cnt; m_search = 0;
                    m_max = (m_cnt == (1 << m_len) - 1);
                end else if (m_cnt == (1 << m_len)) begin
                    m_to = 1; m_search = 0;
                end
            end
            m_state = nx;
        end
    end

    // compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (live) begin
            chk(int'(state) == m_state, "R1 state", int'(state), m_state);
            chk(int'(out_bit) == (m_state & 1), "R1 out_bit", int'(out_bit), m_state & 1);
            chk(period_valid == m_valid, "R6 period_valid", int'(period_valid), int'(m_valid));
            chk(int'(period) == m_period, "R6 period", int'(period), m_period);
            chk(maximal == m_max, "R7 maximal", int'(maximal), int'(m_max));
            chk(lockup == m_lock, "R8 lockup", int'(lockup), int'(m_lock));
            chk(timeout == m_to, "R9 timeout", int'(timeout), int'(m_to));
        end
    end

    task automatic do_load(int n, int t, int s, bit with_step);
        @(negedge clk);
        cfg_len = 5'(n); cfg_taps = 20'(t); cfg_seed = 20'(s);
        cfg_load = 1'b1; step_en = with_step;
        @(negedge clk);
        cfg_load = 1'b0; step_en = 1'b0;
    endtask

    task automatic run(int k);
        step_en = 1'b1;
        repeat (k) @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic expect_max(int n, int t, string req);
        do_load(n, t, 1, 1'b0);
        run((1 << n) - 1);
        chk(period_valid && int'(period) == (1 << n) - 1, req, int'(period), (1 << n) - 1);
        chk(maximal, req, int'(maximal), 1);
    endtask

    initial begin
        logic [14:0] seq;
        logic [19:0] held;
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(state == '0 && out_bit == 1'b0, "R10 state", int'(state), 0);
        chk(!period_valid && !maximal && !lockup && !timeout && period == '0,
            "R10 status", int'({period_valid, maximal, lockup, timeout}), 0);
        rst_n = 1'b1;
        live = 1;

        // R2: n=4, taps {4,1}, seed 1000
        do_load(4, 'h9, 'h8, 1'b0);
        step_en = 1'b1;
        for (int i = 0; i < 15; i++) begin
            seq[14 - i] = out_bit;
            @(negedge clk);
        end
        step_en = 1'b0;
        chk(seq == 15'b000111101011001, "R2 sequence", int'(seq), 15'b000111101011001);
        chk(period_valid && period == 20'd15, "R2 period", int'(period), 15);
        chk(maximal, "R7 n=4", int'(maximal), 1);

        // R5: idle cycles hold everything
        held = state;
        repeat (4) @(negedge clk);
        chk(state == held && period_valid, "R5 hold", int'(state), int'(held));

        // R7: reference maximal tap sets
        expect_max(3, 'h6, "R7 n=3");
        expect_max(5, 'h12, "R7 n=5");
        expect_max(8, 'h8E, "R7 n=8");
        expect_max(10, 'h204, "R7 n=10");
        expect_max(1, 'h1, "R7 n=1");

        // R7: non-primitive taps give period 5, not maximal
        do_load(4, 'hF, 'h8, 1'b0);
        run(5);
        chk(period_valid && period == 20'd5, "R7 short period", int'(period), 5);
        chk(!maximal, "R7 not maximal", int'(maximal), 0);

        // R9: taps {1} never return to 1000
        do_load(4, 'h1, 'h8, 1'b0);
        run(15);
        chk(!timeout, "R9 before bound", int'(timeout), 0);
        run(1);
        chk(timeout && !period_valid, "R9 at bound", int'(timeout), 1);
        run(6);

        // R8: zero seed, and a seed zero within the length
        do_load(4, 'h9, 'h0, 1'b0);
        run(20);
        chk(lockup && state == '0 && !period_valid && !timeout, "R8 zero seed", int'(state), 0);
        do_load(4, 'h9, 'hF0, 1'b0);
        run(20);
        chk(lockup && state == '0, "R8 upper-only seed", int'(lockup), 1);

        // R3: junk above the length is ignored
        do_load(4, 'hFFFF9, 'hABC8, 1'b0);
        chk(state == 20'h8, "R3 masked seed", int'(state), 8);
        run(15);
        chk(period_valid && period == 20'd15 && state == 20'h8, "R3 masked taps", int'(period), 15);

        // R4: load and step in the same cycle, then a load clears status
        do_load(5, 'h12, 'h1B, 1'b1);
        chk(state == 20'h1B && !period_valid && !maximal, "R4 load priority", int'(state), 'h1B);
        run(31);
        chk(period_valid && period == 20'd31, "R4 full run after load", int'(period), 31);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule